// File: doc/BRIEF.md
# DDR PHY Initialization Sequencer

This block walks a DDR PHY through its bring-up. Software loads three timing words and then writes a control word. That word holds one enable bit per step, a set of skip bits and a start bit. The sequencer then runs the enabled steps, one at a time and always in the same order:

1. DLL soft reset
2. DLL lock wait
3. impedance calibration
4. interface timing reset
5. DRAM reset
6. DRAM initialization
7. DQS gate training
8. read-valid training

Counted steps last for a programmed number of clock cycles. Calibration and the two training steps wait for completion inputs from stub models. Progress, done flags and error flags are kept in a status word that software polls.

Steps are numbered 1 to 8 in the order above. Step k is enabled by control bit k, and output `stepActive[k-1]` is high while step k runs. A short idle cycle separates consecutive steps. An error reported by a training step ends the sequence early. The start bit clears itself when the sequence finishes.

Top module: `ddr_phy_init_seq`

## Requirements
- R1: After reset, busy is low, `stepActive` is zero, and every register reads zero.
- R2: Register addresses are:
  - 0: control. Writable bits are 0-8, 16-18 and 29-31. Bit 28 is accepted on write but always reads 0.
  - 1: status. Bits 0-9 are defined. Bit 7 and bits 10 and above read 0.
  - 2: timing word 0, bits 21:0.
  - 3: timing word 1, bits 26:0.
  - 4: timing word 2, bits 26:0.
  - All other addresses read 0.
- R3: Writing control with bit 0 set starts a sequence. Enabled steps run one at a time in ascending step number. A step whose enable bit is clear never becomes active.
- R4: Counted steps stay active for max(v,1) cycles, where v is the field shown below. Step 6 runs three back-to-back phases of this kind.

  | Step | Word | Bits |
  |------|------|------|
  | 1 | 0 | 5:0 |
  | 2 | 0 | 17:6 |
  | 4 | 0 | 21:18 |
  | 5 | 1 | 18:0 |
  | 6, phase 1 | 1 | 26:19 |
  | 6, phase 2 | 2 | 16:0 |
  | 6, phase 3 | 2 | 26:17 |
- R5: Step 3 stays active until `calDone` is seen high, and step 7 or 8 until `trnDone` is seen high. The step ends on the following edge. On completion, status bit 1 is set by step 2, bit 2 by step 3, bit 3 by step 6, and bit 4 by step 7 or 8.
- R6: Skip bits remove steps from the run as follows:
  - bit 17 skips steps 1 and 2;
  - bit 29 skips step 2 and sets status bit 1 at start;
  - bit 30 skips step 3 and sets status bit 2 at start;
  - bit 18 skips step 6;
  - bit 31 skips all steps.
- R7: When `trnDone` is seen with `trnErr` or `trnIntermit`, the training step reports an error:
  - in step 7, `trnErr` sets status bit 5 and `trnIntermit` sets bit 6;
  - in step 8, `trnErr` sets bit 8 and `trnIntermit` sets bit 9;
  - no later step runs, and status bit 0 is still set.
- R8: At the end of every sequence, on the same edge, status bit 0 is set, control bit 0 clears and busy falls. The other control bits keep their values.
- R9: A control write with bit 28 set clears all status bits. Without bit 28, flags from earlier sequences are kept.
- R10: While busy is high, writes to every register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational from regAddr) |
| calDone | input | 1 | Impedance calibration complete (stub) |
| trnDone | input | 1 | Training step complete (stub) |
| trnErr | input | 1 | Training error, valid with trnDone |
| trnIntermit | input | 1 | Intermittent training error, valid with trnDone |
| busy | output | 1 | Sequence pending or running |
| stepActive | output | 8 | One-hot active step; bit k-1 is step k |

## Verification
The hardest situation to reach is the interaction between skip bits, enable bits and an early abort. Certain combinations must leave a status flag set for a step that never ran, and must stop the run before later steps are reached.

The bench sweeps all 256 step-enable patterns. For each pattern it rotates through a cycle of skip-bit combinations, with timing fields that vary per run and include zero values. It drives the calibration and training stubs with chosen latencies from the observed `stepActive` vector. It then compares the observed step order, each step's duration and the final status against values computed from the control word.

Directed runs cover the following cases:
- training errors in each training step;
- status accumulation without a clear;
- writes made mid-sequence.

// File: rtl/ddr_phy_init_seq_pkg.sv
package ddr_phy_init_seq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int STEP_N  = 8;
  localparam int STEP_IW = $clog2(STEP_N);
  localparam int STAT_W  = 10;
  localparam int CNT_W   = 19;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_T1   = 3'd3;
  localparam logic [ADDR_W-1:0] A_T2   = 3'd4;

  localparam int CB_TRIG    = 0;
  localparam int CB_DLLBYP  = 17;
  localparam int CB_CTLINIT = 18;
  localparam int CB_CLR     = 28;
  localparam int CB_LOCKBYP = 29;
  localparam int CB_ZQBYP   = 30;
  localparam int CB_INITBYP = 31;

  localparam logic [REG_W-1:0] CTRL_MASK = 32'hE007_01FF;
  localparam logic [REG_W-1:0] T0_MASK   = 32'h003F_FFFF;
  localparam logic [REG_W-1:0] T12_MASK  = 32'h07FF_FFFF;

  localparam int ST_INIT   = 0;
  localparam int ST_LOCK   = 1;
  localparam int ST_ZQ     = 2;
  localparam int ST_DINIT  = 3;
  localparam int ST_TRN    = 4;
  localparam int ST_GERR   = 5;
  localparam int ST_GIERR  = 6;
  localparam int ST_RVERR  = 8;
  localparam int ST_RVIERR = 9;

  // step indices (step number minus one)
  localparam int IX_SRST  = 0;
  localparam int IX_LOCK  = 1;
  localparam int IX_ZQ    = 2;
  localparam int IX_ITM   = 3;
  localparam int IX_DRST  = 4;
  localparam int IX_DINIT = 5;
  localparam int IX_GATE  = 6;
  localparam int IX_RVAL  = 7;

  typedef enum logic [2:0] {
    SEL_SRST, SEL_LOCK, SEL_ITM, SEL_DI0, SEL_DI1, SEL_DI2, SEL_DI3
  } cntSel_e;

  typedef struct packed {
    logic              cntLoad;
    cntSel_e           cntSel;
    logic              cntDec;
    logic [STAT_W-1:0] statSet;
    logic              trigClr;
  } seqStrobe_t;
endpackage

// File: rtl/ddr_phy_init_seq_regs.sv
module ddr_phy_init_seq_regs
  import ddr_phy_init_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              busy,
  input  seqStrobe_t        stb,
  output logic [REG_W-1:0]  ctrlQ,
  output logic              cntLast
);
  logic [REG_W-1:0]  t0Q, t1Q, t2Q;
  logic [STAT_W-1:0] statQ;
  logic [CNT_W-1:0]  cnt, fieldVal, loadVal;
  logic              wrOk, clrStat;

  assign wrOk    = regWr && !busy;
  assign clrStat = wrOk && (regAddr == A_CTRL) && regWdata[CB_CLR];

  always_comb begin
    fieldVal = '0;
    unique case (stb.cntSel)
      SEL_SRST: fieldVal = CNT_W'(t0Q[5:0]);
      SEL_LOCK: fieldVal = CNT_W'(t0Q[17:6]);
      SEL_ITM:  fieldVal = CNT_W'(t0Q[21:18]);
      SEL_DI0:  fieldVal = t1Q[18:0];
      SEL_DI1:  fieldVal = CNT_W'(t1Q[26:19]);
      SEL_DI2:  fieldVal = CNT_W'(t2Q[16:0]);
      SEL_DI3:  fieldVal = CNT_W'(t2Q[26:17]);
      default:  fieldVal = '0;
    endcase
    loadVal = (fieldVal == '0) ? CNT_W'(1) : fieldVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      t0Q   <= '0;
      t1Q   <= '0;
      t2Q   <= '0;
    end else begin
      if (wrOk) begin
        unique case (regAddr)
          A_CTRL:  ctrlQ <= regWdata & CTRL_MASK;
          A_T0:    t0Q   <= regWdata & T0_MASK;
          A_T1:    t1Q   <= regWdata & T12_MASK;
          A_T2:    t2Q   <= regWdata & T12_MASK;
          default: ;
        endcase
      end
      if (stb.trigClr) ctrlQ[CB_TRIG] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (clrStat ? '0 : statQ) | stb.statSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (stb.cntLoad) cnt <= loadVal;
    else if (stb.cntDec)  cnt <= cnt - 1'b1;
  end

  assign cntLast = (cnt <= CNT_W'(1));

  always_comb begin
    unique case (regAddr)
      A_CTRL:  regRdata = ctrlQ;
      A_STAT:  regRdata = {{(REG_W-STAT_W){1'b0}}, statQ};
      A_T0:    regRdata = t0Q;
      A_T1:    regRdata = t1Q;
      A_T2:    regRdata = t2Q;
      default: regRdata = '0;
    endcase
  end

  assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntDec |-> (cnt > CNT_W'(1)));

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (statQ[ST_INIT] && !ctrlQ[CB_TRIG]));

  assert_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && busy) |=> ($stable(t0Q) && $stable(t1Q) && $stable(t2Q)));
endmodule

// File: rtl/ddr_phy_init_seq_ctrl.sv
module ddr_phy_init_seq_ctrl
  import ddr_phy_init_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  ctrlQ,
  input  logic              cntLast,
  input  logic              calDone,
  input  logic              trnDone,
  input  logic              trnErr,
  input  logic              trnIntermit,
  output seqStrobe_t        stb,
  output logic              busy,
  output logic [STEP_N-1:0] stepActive
);
  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_COUNT, S_WAIT} seqState_e;

  seqState_e          state;
  logic [STEP_IW-1:0] curStep, pick;
  logic [1:0]         subPh;
  logic [STEP_N-1:0]  remain;
  logic               trnBad;
  logic               unusedBits;

  assign unusedBits = ^{ctrlQ[16:9], ctrlQ[28:19]};
  assign trnBad     = trnErr || trnIntermit;

  function automatic logic [STEP_N-1:0] runMask(input logic [REG_W-1:0] c);
    logic [STEP_N-1:0] m;
    m = c[STEP_N:1];
    if (c[CB_DLLBYP])  begin m[IX_SRST] = 1'b0; m[IX_LOCK] = 1'b0; end
    if (c[CB_LOCKBYP]) m[IX_LOCK]  = 1'b0;
    if (c[CB_ZQBYP])   m[IX_ZQ]    = 1'b0;
    if (c[CB_CTLINIT]) m[IX_DINIT] = 1'b0;
    if (c[CB_INITBYP]) m = '0;
    return m;
  endfunction

  function automatic logic [STEP_IW-1:0] lowIdx(input logic [STEP_N-1:0] m);
    logic [STEP_IW-1:0] r;
    r = '0;
    for (int i = STEP_N - 1; i >= 0; i--) if (m[i]) r = STEP_IW'(i);
    return r;
  endfunction

  function automatic logic isCounted(input logic [STEP_IW-1:0] ix);
    return !(ix == STEP_IW'(IX_ZQ) || ix == STEP_IW'(IX_GATE) || ix == STEP_IW'(IX_RVAL));
  endfunction

  function automatic cntSel_e firstSel(input logic [STEP_IW-1:0] ix);
    cntSel_e s;
    case (ix)
      STEP_IW'(IX_SRST): s = SEL_SRST;
      STEP_IW'(IX_LOCK): s = SEL_LOCK;
      STEP_IW'(IX_ITM):  s = SEL_ITM;
      STEP_IW'(IX_DRST): s = SEL_DI0;
      default:           s = SEL_DI1;
    endcase
    return s;
  endfunction

  assign pick = lowIdx(remain);

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE: if (ctrlQ[CB_TRIG]) begin
        stb.statSet[ST_LOCK] = ctrlQ[CB_LOCKBYP];
        stb.statSet[ST_ZQ]   = ctrlQ[CB_ZQBYP];
      end
      S_NEXT: begin
        if (remain == '0) begin
          stb.statSet[ST_INIT] = 1'b1;
          stb.trigClr          = 1'b1;
        end else if (isCounted(pick)) begin
          stb.cntLoad = 1'b1;
          stb.cntSel  = firstSel(pick);
        end
      end
      S_COUNT: begin
        if (!cntLast) begin
          stb.cntDec = 1'b1;
        end else if (curStep == STEP_IW'(IX_DINIT) && subPh != 2'd2) begin
          stb.cntLoad = 1'b1;
          stb.cntSel  = (subPh == 2'd0) ? SEL_DI2 : SEL_DI3;
        end else begin
          stb.statSet[ST_LOCK]  = (curStep == STEP_IW'(IX_LOCK));
          stb.statSet[ST_DINIT] = (curStep == STEP_IW'(IX_DINIT));
        end
      end
      S_WAIT: begin
        if (curStep == STEP_IW'(IX_ZQ)) begin
          stb.statSet[ST_ZQ] = calDone;
        end else if (trnDone) begin
          stb.statSet[ST_TRN] = 1'b1;
          if (curStep == STEP_IW'(IX_GATE)) begin
            stb.statSet[ST_GERR]  = trnErr;
            stb.statSet[ST_GIERR] = trnIntermit;
          end else begin
            stb.statSet[ST_RVERR]  = trnErr;
            stb.statSet[ST_RVIERR] = trnIntermit;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curStep <= '0;
      subPh   <= '0;
      remain  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (ctrlQ[CB_TRIG]) begin
          remain <= runMask(ctrlQ);
          state  <= S_NEXT;
        end
        S_NEXT: begin
          if (remain == '0) begin
            state <= S_IDLE;
          end else begin
            curStep      <= pick;
            remain[pick] <= 1'b0;
            subPh        <= '0;
            state        <= isCounted(pick) ? S_COUNT : S_WAIT;
          end
        end
        S_COUNT: if (cntLast) begin
          if (curStep == STEP_IW'(IX_DINIT) && subPh != 2'd2) subPh <= subPh + 2'd1;
          else state <= S_NEXT;
        end
        S_WAIT: begin
          if (curStep == STEP_IW'(IX_ZQ)) begin
            if (calDone) state <= S_NEXT;
          end else if (trnDone) begin
            if (trnBad) remain <= '0;
            state <= S_NEXT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE) || ctrlQ[CB_TRIG];
  assign stepActive = (state == S_COUNT || state == S_WAIT) ?
                      (STEP_N'(1) << curStep) : '0;

  assert_skip_dll_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlQ[CB_DLLBYP]) |-> (stepActive[IX_LOCK:IX_SRST] == 2'b00));

  assert_skip_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlQ[CB_INITBYP]) |-> (stepActive == '0));

  assert_cal_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepActive[IX_ZQ] && calDone) |=> (stepActive == '0));

  assert_err_halts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepActive[IX_GATE] && trnDone && trnErr) |-> ##2 !busy);
endmodule

// File: rtl/ddr_phy_init_seq.sv
module ddr_phy_init_seq
  import ddr_phy_init_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              calDone,
  input  logic              trnDone,
  input  logic              trnErr,
  input  logic              trnIntermit,
  output logic              busy,
  output logic [STEP_N-1:0] stepActive
);
  seqStrobe_t       stb;
  logic [REG_W-1:0] ctrlQ;
  logic             cntLast;

  ddr_phy_init_seq_regs u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy),
    .stb(stb), .ctrlQ(ctrlQ), .cntLast(cntLast)
  );

  ddr_phy_init_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .cntLast(cntLast),
    .calDone(calDone), .trnDone(trnDone), .trnErr(trnErr),
    .trnIntermit(trnIntermit), .stb(stb), .busy(busy),
    .stepActive(stepActive)
  );
endmodule

// File: tb/ddr_phy_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_phy_init_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        calDone = 1'b0, trnDone = 1'b0, trnErr = 1'b0, trnIntermit = 1'b0;
  logic        busy;
  logic [7:0]  stepActive;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int obsOrder[16];
  int obsN;
  int obsDur[9];

  always #4 clk = ~clk;

  ddr_phy_init_seq u_ddr_phy_init_seq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .calDone(calDone),
    .trnDone(trnDone), .trnErr(trnErr), .trnIntermit(trnIntermit),
    .busy(busy), .stepActive(stepActive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic int mx(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic runSeq(input logic [31:0] cw, input int calLat, input int trnLat,
                        input bit e7, input bit e8, input bit im);
    int calC = 0, trnC = 0, guard = 0;
    logic [7:0] prev = '0;
    obsN = 0;
    for (int s = 0; s < 9; s++) obsDur[s] = 0;
    regWrite(3'd0, cw);
    do begin
      @(negedge clk);
      if (stepActive != 8'h00 && stepActive != prev && obsN < 16) begin
        for (int k = 0; k < 8; k++) if (stepActive[k]) obsOrder[obsN] = k + 1;
        obsN++;
      end
      for (int k = 0; k < 8; k++) if (stepActive[k]) obsDur[k+1]++;
      calDone = 0; trnDone = 0; trnErr = 0; trnIntermit = 0;
      if (stepActive[2]) begin
        calC++;
        if (calC == calLat) calDone = 1;
      end else calC = 0;
      if (stepActive[6] || stepActive[7]) begin
        trnC++;
        if (trnC == trnLat) begin
          trnDone = 1;
          if ((stepActive[6] && e7) || (stepActive[7] && e8)) begin
            trnErr = 1; trnIntermit = im;
          end
        end
      end else trnC = 0;
      prev = stepActive;
      guard++;
    end while (busy && guard < 5000);
    calDone = 0; trnDone = 0; trnErr = 0; trnIntermit = 0;
  endtask

  task automatic checkRun(input logic [31:0] cw, input logic [31:0] prevStat,
                          input int srst, input int lock, input int itm, input int d0,
                          input int d1, input int d2, input int d3,
                          input int calLat, input int trnLat, input bit e7, input bit e8, input bit im);
    logic [31:0] expSt, got, expOrdW, obsOrdW;
    int expDur[9];
    int n = 0;
    bit stop = 0;
    string otag;
    expSt = cw[28] ? 32'h0 : prevStat;
    if (cw[29]) expSt |= 32'h2;
    if (cw[30]) expSt |= 32'h4;
    expOrdW = '0;
    for (int s = 1; s <= 8; s++) begin
      bit run = cw[s];
      expDur[s] = 0;
      if ((s == 1 || s == 2) && cw[17]) run = 0;
      if (s == 2 && cw[29]) run = 0;
      if (s == 3 && cw[30]) run = 0;
      if (s == 6 && cw[18]) run = 0;
      if (cw[31]) run = 0;
      if (run && !stop) begin
        expOrdW = (expOrdW << 4) | 32'(s);
        n++;
        case (s)
          1: expDur[s] = mx(srst);
          2: begin expDur[s] = mx(lock); expSt |= 32'h2; end
          3: begin expDur[s] = calLat; expSt |= 32'h4; end
          4: expDur[s] = mx(itm);
          5: expDur[s] = mx(d0);
          6: begin expDur[s] = mx(d1) + mx(d2) + mx(d3); expSt |= 32'h8; end
          7: begin
            expDur[s] = trnLat; expSt |= 32'h10;
            if (e7) begin expSt |= 32'h20 | (im ? 32'h40 : 0); stop = 1; end
          end
          default: begin
            expDur[s] = trnLat; expSt |= 32'h10;
            if (e8) begin expSt |= 32'h100 | (im ? 32'h200 : 0); stop = 1; end
          end
        endcase
      end
    end
    expSt |= 32'h1;
    obsOrdW = '0;
    for (int i = 0; i < obsN && i < 8; i++) obsOrdW = (obsOrdW << 4) | 32'(obsOrder[i]);
    otag = ((cw & 32'h6006_0000) != 0 || cw[31]) ? "R6 skip/order" : "R3 order";
    chk(obsN == n && obsOrdW == expOrdW, otag, obsOrdW, expOrdW);
    for (int s = 1; s <= 8; s++) begin
      if (expDur[s] == 0)
        chk(obsDur[s] == 0, "R3 disabled step inactive", 32'(obsDur[s]), 0);
      else if (s == 3 || s == 7 || s == 8)
        chk(obsDur[s] == expDur[s], "R5 stub step duration", 32'(obsDur[s]), 32'(expDur[s]));
      else
        chk(obsDur[s] == expDur[s], "R4 counted step duration", 32'(obsDur[s]), 32'(expDur[s]));
    end
    regRead(3'd1, got);
    chk(got == expSt, (e7 || e8) ? "R7 status" : "R5 status", got, expSt);
    regRead(3'd0, got);
    chk(got == ((cw & 32'hE007_01FF) & ~32'h1) && !busy, "R8 trigger self-clear", got,
        (cw & 32'hE007_01FF) & ~32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, st0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), rd);
      chk(rd == 0, "R1 reset register", rd, 0);
    end
    chk(!busy && stepActive == 0, "R1 reset outputs", {busy, stepActive}, 0);

    // R2 register map
    regWrite(3'd2, 32'hFFFF_FFFF); regRead(3'd2, rd); chk(rd == 32'h003F_FFFF, "R2 timing0", rd, 32'h003F_FFFF);
    regWrite(3'd3, 32'hFFFF_FFFF); regRead(3'd3, rd); chk(rd == 32'h07FF_FFFF, "R2 timing1", rd, 32'h07FF_FFFF);
    regWrite(3'd4, 32'hFFFF_FFFF); regRead(3'd4, rd); chk(rd == 32'h07FF_FFFF, "R2 timing2", rd, 32'h07FF_FFFF);
    regWrite(3'd0, 32'hFFFF_FFFE); regRead(3'd0, rd); chk(rd == 32'hE007_01FE, "R2 control mask", rd, 32'hE007_01FE);
    chk(!busy, "R2 no start without bit 0", busy, 0);
    regRead(3'd5, rd); chk(rd == 0, "R2 unmapped address", rd, 0);
    regRead(3'd1, rd); chk(rd == 0, "R2 status idle", rd, 0);
    regWrite(3'd0, 32'h0);

    // sweep over every enable pattern with rotating skip bits and timings
    for (int r = 0; r < 256; r++) begin
      int srst = r % 4, lock = 1 + r % 3, itm = r % 2, d0 = r % 5, d1 = r % 3, d2 = 2, d3 = r % 2;
      int calLat = 1 + r % 3, trnLat = 1 + r % 2;
      int bp = (r * 5) % 16;
      logic [31:0] cw;
      cw = 32'h1 | (32'(r) << 1) | (32'h1 << 28);
      if (bp[0]) cw |= 32'h1 << 17;
      if (bp[1]) cw |= 32'h1 << 18;
      if (bp[2]) cw |= 32'h1 << 29;
      if (bp[3]) cw |= 32'h1 << 30;
      if (r % 37 == 5) cw |= 32'h1 << 31;
      regWrite(3'd2, 32'(srst) | (32'(lock) << 6) | (32'(itm) << 18));
      regWrite(3'd3, 32'(d0) | (32'(d1) << 19));
      regWrite(3'd4, 32'(d2) | (32'(d3) << 17));
      runSeq(cw, calLat, trnLat, 0, 0, 0);
      checkRun(cw, 0, srst, lock, itm, d0, d1, d2, d3, calLat, trnLat, 0, 0, 0);
    end

    // R7 training errors
    regWrite(3'd2, 32'h0); regWrite(3'd3, 32'h0); regWrite(3'd4, 32'h0);
    runSeq(32'h1000_01C3, 2, 2, 1, 0, 1);
    checkRun(32'h1000_01C3, 0, 0, 0, 0, 0, 0, 0, 0, 2, 2, 1, 0, 1);
    runSeq(32'h1000_0181, 2, 3, 0, 1, 0);
    checkRun(32'h1000_0181, 0, 0, 0, 0, 0, 0, 0, 0, 2, 3, 0, 1, 0);

    // R9 accumulation without clear, then clear alone
    runSeq(32'h1000_0009, 2, 1, 0, 0, 0);
    checkRun(32'h1000_0009, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 0, 0);
    regRead(3'd1, st0);
    runSeq(32'h0000_0041, 1, 1, 0, 0, 0);
    regRead(3'd1, rd);
    chk(rd == 32'hD, "R9 status accumulates", rd, 32'hD);
    checkRun(32'h0000_0041, st0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    regWrite(3'd0, 32'h1000_0000);
    regRead(3'd1, rd);
    chk(rd == 0, "R9 clear status", rd, 0);

    // R10 writes ignored while busy
    regWrite(3'd3, 32'd40);
    regWrite(3'd0, 32'h3000_0021);
    regWrite(3'd3, 32'h0);
    regWrite(3'd0, 32'h1000_0000);
    chk(busy == 1'b1, "R10 still busy during writes", busy, 1);
    for (int g = 0; g < 200 && busy; g++) @(negedge clk);
    regRead(3'd3, rd);
    chk(rd == 32'd40, "R10 timing write ignored", rd, 32'd40);
    regRead(3'd1, rd);
    chk(rd == 32'h3, "R10 clear ignored", rd, 32'h3);
    regRead(3'd0, rd);
    chk(rd == 32'h2000_0020, "R10 control write ignored", rd, 32'h2000_0020);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule